// File: doc/BRIEF.md
# Processor Mode Register and Memory Map Decoder

This block holds the 16-bit mode word of a processor core and turns its fields into the signals that steer the memory system. Software writes the whole word in one cycle over a plain write strobe and reads it back in full. A hardware reset loads a fixed value into most fields. It also samples an external mode pin into the bit that switches the on-chip ROM. A separate software reset request clears only the low six bits.

From the stored word the block forms four kinds of output. The first is the full address of an interrupt vector, taken from a 9-bit page pointer and a 7-bit vector number. The second is a set of hit signals that tell whether a program-space or a data-space address falls on on-chip ROM or on-chip RAM. The third is the value on the external address pins, which either tracks internal program fetches or keeps the last address driven. The fourth is a clock output that can be parked high. The memory arrays, the core and the interrupt controller are outside the block.

Top module: `pmode_ctrl`

## Requirements
- R1: While `rst` is high at a rising clock edge, the word becomes pointer 1FFh in bits 15..7, the level of `mode_pin` in bit 6, and zeros in bits 5..0. The word can be read on `rd_data` from the next cycle.
- R2: When `wr_en` is high and neither `rst` nor `soft_rst` is high, all 16 bits of `wr_data` appear on `rd_data` after that clock edge.
- R3: When `soft_rst` is high, bits 15..6 are kept and bits 5..0 are cleared at the next edge. This takes priority over a write in the same cycle.
- R4: `vec_addr` equals the pointer (bits 15..7) followed by `vec_num`, so right after a hardware reset a `vec_num` of 0 gives FF80h.
- R5: `prog_rom_sel` is high exactly when bit 6 is 0 and `prog_addr` lies in F000h–FFFFh.
- R6: `prog_ram_sel` is high exactly when bit 5 is 1 and `prog_addr` lies in 0080h–3FFFh. A program address in 0000h–007Fh never selects RAM.
- R7: `data_ram_sel` is high exactly when `data_addr` lies in 0080h–3FFFh, whatever the value of bit 5.
- R8: `data_rom_sel` is high exactly when bit 3 is 1 and `data_addr` lies in F000h–FFFFh.
- R9: `ext_addr` is a register that clears to 0 on hardware reset. When `ext_valid` is high it loads `ext_bus_addr`. Otherwise, when bit 4 is 1 and `prog_fetch` is high, it loads `prog_addr`. In every other case it holds its value.
- R10: While bit 2 is 1, `clk_out` stays high. While bit 2 is 0, `clk_out` follows `clk`.
- R11: `mode_pin` has no effect on the word outside a hardware reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous hardware reset, active high |
| mode_pin | input | 1 | ROM-disable strap, sampled only under reset |
| soft_rst | input | 1 | Software reset request |
| wr_en | input | 1 | Write strobe for the mode word |
| wr_data | input | 16 | New mode word |
| rd_data | output | 16 | Current mode word |
| vec_num | input | 7 | Interrupt vector number |
| vec_addr | output | 16 | Program address of that vector |
| prog_addr | input | 16 | Internal program address |
| prog_fetch | input | 1 | A program fetch is in progress this cycle |
| prog_rom_sel | output | 1 | Program address hits on-chip ROM |
| prog_ram_sel | output | 1 | Program address hits overlay RAM |
| data_addr | input | 16 | Internal data address |
| data_rom_sel | output | 1 | Data address hits on-chip ROM |
| data_ram_sel | output | 1 | Data address hits on-chip RAM |
| ext_valid | input | 1 | An external bus access drives `ext_bus_addr` |
| ext_bus_addr | input | 16 | Address of that external access |
| ext_addr | output | 16 | Value on the external address pins |
| clk_out | output | 1 | Clock output, parked high when disabled |

## Verification
The hardest case to reach is the state set by a software reset. It must keep a ROM-disable bit that was loaded from the pin but later changed by software, and it must do so while a write competes for the same edge. The stimulus first resets with the pin high, then writes a word that clears bit 6, sets every low bit and moves the pointer. It then raises the soft reset and a different write in the same cycle. The page-0 exclusion and the hold of the external pins are covered by sweeping program and data addresses across every range edge while overlay, visibility and fetch are turned on and off in turn.

// File: rtl/pmode_pkg.sv
package pmode_pkg;

    localparam int VPTR_W = 9;
    localparam int VOFS_W = 7;
    localparam int AW     = VPTR_W + VOFS_W;
    localparam int LOW_W  = 6;

    typedef struct packed {
        logic [VPTR_W-1:0] vptr;
        logic              rom_off;
        logic              ovl;
        logic              avis;
        logic              drom;
        logic              clk_off;
        logic              smul;
        logic              sst;
    } pmode_t;

    typedef enum logic {SPACE_PROG = 1'b0, SPACE_DATA = 1'b1} space_e;

    function automatic logic in_range(input logic [AW-1:0] a,
                                      input logic [AW-1:0] lo,
                                      input logic [AW-1:0] hi);
        return (a >= lo) && (a <= hi);
    endfunction

    function automatic pmode_t hw_reset_word(input logic pin);
        pmode_t w;
        w         = '0;
        w.vptr    = '1;
        w.rom_off = pin;
        return w;
    endfunction

    function automatic pmode_t soft_reset_word(input pmode_t cur);
        pmode_t w;
        w         = '0;
        w.vptr    = cur.vptr;
        w.rom_off = cur.rom_off;
        return w;
    endfunction

endpackage

// File: rtl/pmode_reg.sv
module pmode_reg
    import pmode_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          mode_pin,
    input  logic          soft_rst,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_data,
    output pmode_t        word
);
    pmode_t word_q;

    always_ff @(posedge clk) begin
        if (rst)
            word_q <= hw_reset_word(mode_pin);
        else if (soft_rst)
            word_q <= soft_reset_word(word_q);
        else if (wr_en)
            word_q <= pmode_t'(wr_data);
    end

    assign word = word_q;
endmodule

// File: rtl/pmode_decode.sv
module pmode_decode
    import pmode_pkg::*;
#(
    parameter space_e         SPACE  = SPACE_PROG,
    parameter logic [AW-1:0]  ROM_LO = 16'hF000,
    parameter logic [AW-1:0]  ROM_HI = 16'hFFFF,
    parameter logic [AW-1:0]  RAM_LO = 16'h0080,
    parameter logic [AW-1:0]  RAM_HI = 16'h3FFF
) (
    input  pmode_t        word,
    input  logic [AW-1:0] addr,
    output logic          rom_sel,
    output logic          ram_sel
);
    logic hit_rom;
    logic hit_ram;
    logic page0;

    assign hit_rom = in_range(addr, ROM_LO, ROM_HI);
    assign hit_ram = in_range(addr, RAM_LO, RAM_HI);
    assign page0   = (addr[AW-1:VOFS_W] == '0);

    generate
        if (SPACE == SPACE_PROG) begin : g_prog
            assign rom_sel = !word.rom_off && hit_rom;
            assign ram_sel = word.ovl && hit_ram && !page0;
        end else begin : g_data
            assign rom_sel = word.drom && hit_rom;
            assign ram_sel = hit_ram;
        end
    endgenerate
endmodule

// File: rtl/pmode_pins.sv
module pmode_pins
    import pmode_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  pmode_t        word,
    input  logic [AW-1:0] prog_addr,
    input  logic          prog_fetch,
    input  logic          ext_valid,
    input  logic [AW-1:0] ext_bus_addr,
    output logic [AW-1:0] ext_addr,
    output logic          clk_out
);
    logic [AW-1:0] pins_q;

    always_ff @(posedge clk) begin
        if (rst)
            pins_q <= '0;
        else if (ext_valid)
            pins_q <= ext_bus_addr;
        else if (word.avis && prog_fetch)
            pins_q <= prog_addr;
    end

    assign ext_addr = pins_q;
    // word changes only at a rising edge, while clk is already high
    assign clk_out  = clk | word.clk_off;
endmodule

// File: rtl/pmode_ctrl.sv
module pmode_ctrl
    import pmode_pkg::*;
#(
    parameter logic [15:0] ROM_LO = 16'hF000,
    parameter logic [15:0] ROM_HI = 16'hFFFF,
    parameter logic [15:0] RAM_LO = 16'h0080,
    parameter logic [15:0] RAM_HI = 16'h3FFF
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        mode_pin,
    input  logic        soft_rst,
    input  logic        wr_en,
    input  logic [15:0] wr_data,
    output logic [15:0] rd_data,
    input  logic [6:0]  vec_num,
    output logic [15:0] vec_addr,
    input  logic [15:0] prog_addr,
    input  logic        prog_fetch,
    output logic        prog_rom_sel,
    output logic        prog_ram_sel,
    input  logic [15:0] data_addr,
    output logic        data_rom_sel,
    output logic        data_ram_sel,
    input  logic        ext_valid,
    input  logic [15:0] ext_bus_addr,
    output logic [15:0] ext_addr,
    output logic        clk_out
);
    pmode_t word;

    pmode_reg u_reg (
        .clk      (clk),
        .rst      (rst),
        .mode_pin (mode_pin),
        .soft_rst (soft_rst),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .word     (word)
    );

    pmode_decode #(.SPACE(SPACE_PROG), .ROM_LO(ROM_LO), .ROM_HI(ROM_HI),
                   .RAM_LO(RAM_LO), .RAM_HI(RAM_HI)) u_pdec (
        .word    (word),
        .addr    (prog_addr),
        .rom_sel (prog_rom_sel),
        .ram_sel (prog_ram_sel)
    );

    pmode_decode #(.SPACE(SPACE_DATA), .ROM_LO(ROM_LO), .ROM_HI(ROM_HI),
                   .RAM_LO(RAM_LO), .RAM_HI(RAM_HI)) u_ddec (
        .word    (word),
        .addr    (data_addr),
        .rom_sel (data_rom_sel),
        .ram_sel (data_ram_sel)
    );

    pmode_pins u_pins (
        .clk          (clk),
        .rst          (rst),
        .word         (word),
        .prog_addr    (prog_addr),
        .prog_fetch   (prog_fetch),
        .ext_valid    (ext_valid),
        .ext_bus_addr (ext_bus_addr),
        .ext_addr     (ext_addr),
        .clk_out      (clk_out)
    );

    assign rd_data  = word;
    assign vec_addr = {word.vptr, vec_num};
endmodule

// File: rtl/pmode_chk.sv
module pmode_chk (
    input logic        clk,
    input logic        rst,
    input logic        mode_pin,
    input logic        soft_rst,
    input logic        wr_en,
    input logic [15:0] wr_data,
    input logic [15:0] rd_data,
    input logic [15:0] prog_addr,
    input logic        prog_fetch,
    input logic        prog_rom_sel,
    input logic        prog_ram_sel,
    input logic        ext_valid,
    input logic [15:0] ext_addr,
    input logic        clk_out
);
    logic was_rst;
    logic seen_clk;

    always_ff @(posedge clk) begin
        was_rst  <= rst;
        seen_clk <= 1'b1;
    end

    // R1: the word one cycle after a hardware reset
    always_ff @(posedge clk) begin
        if (seen_clk && was_rst && !rst)
            assert_hwrst_R1: assert (rd_data[15:7] == 9'h1FF && rd_data[5:0] == 6'd0);
    end

    assert_write_R2: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !soft_rst) |=> (rd_data == $past(wr_data)));

    assert_softrst_R3: assert property (@(posedge clk) disable iff (rst)
        soft_rst |=> (rd_data[15:6] == $past(rd_data[15:6]) && rd_data[5:0] == 6'd0));

    assert_page0_R6: assert property (@(posedge clk) disable iff (rst)
        (prog_addr[15:7] == 9'd0) |-> !prog_ram_sel);

    assert_romram_R5: assert property (@(posedge clk) disable iff (rst)
        !(prog_rom_sel && prog_ram_sel));

    assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (!ext_valid && !(rd_data[4] && prog_fetch)) |=> $stable(ext_addr));

    assert_clkoff_R10: assert property (@(negedge clk) disable iff (rst)
        rd_data[2] |-> clk_out);

    assert_pin_R11: assert property (@(posedge clk) disable iff (rst)
        (!soft_rst && !wr_en) |=> $stable(rd_data));
endmodule

bind pmode_ctrl pmode_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .mode_pin     (mode_pin),
    .soft_rst     (soft_rst),
    .wr_en        (wr_en),
    .wr_data      (wr_data),
    .rd_data      (rd_data),
    .prog_addr    (prog_addr),
    .prog_fetch   (prog_fetch),
    .prog_rom_sel (prog_rom_sel),
    .prog_ram_sel (prog_ram_sel),
    .ext_valid    (ext_valid),
    .ext_addr     (ext_addr),
    .clk_out      (clk_out)
);

// File: tb/sim_pmode_ctrl.sv
`timescale 1ns/1ps
module sim_pmode_ctrl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        mode_pin = 1'b1;
    logic        soft_rst = 1'b0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_data = '0;
    logic [15:0] rd_data;
    logic [6:0]  vec_num = '0;
    logic [15:0] vec_addr;
    logic [15:0] prog_addr = '0;
    logic        prog_fetch = 1'b0;
    logic        prog_rom_sel, prog_ram_sel;
    logic [15:0] data_addr = '0;
    logic        data_rom_sel, data_ram_sel;
    logic        ext_valid = 1'b0;
    logic [15:0] ext_bus_addr = '0;
    logic [15:0] ext_addr;
    logic        clk_out;

    int tests = 0;
    int fails = 0;
    bit done = 0;

    always #5 clk = ~clk;

    pmode_ctrl u0 (.*);

    // behavioural reference
    logic [15:0] m_word;
    logic [15:0] m_ext;
    bit          m_live = 0;

    always @(posedge clk) begin
        m_live <= 1;
        if (rst) begin
            m_word <= {9'h1FF, mode_pin, 6'b0};
            m_ext  <= 16'h0000;
        end else begin
            if (soft_rst)   m_word <= {m_word[15:6], 6'b0};
            else if (wr_en) m_word <= wr_data;
            if (ext_valid)                     m_ext <= ext_bus_addr;
            else if (m_word[4] && prog_fetch)  m_ext <= prog_addr;
        end
    end

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s at %0t: actual %h expected %h", req, $time, act, exp);
        end
    endtask

    function automatic bit rng(input logic [15:0] a, input int lo, input int hi);
        return (int'(a) >= lo) && (int'(a) <= hi);
    endfunction

    always @(negedge clk) begin
        if (m_live && !done) begin
            chk("R1/R2/R3/R11 rd_data", rd_data, m_word);
            chk("R4 vec_addr", vec_addr, {m_word[15:7], vec_num});
            chk("R5 prog_rom_sel", {15'd0, prog_rom_sel},
                {15'd0, !m_word[6] && rng(prog_addr, 16'hF000, 16'hFFFF)});
            chk("R6 prog_ram_sel", {15'd0, prog_ram_sel},
                {15'd0, m_word[5] && rng(prog_addr, 16'h0080, 16'h3FFF)});
            chk("R7 data_ram_sel", {15'd0, data_ram_sel},
                {15'd0, rng(data_addr, 16'h0080, 16'h3FFF)});
            chk("R8 data_rom_sel", {15'd0, data_rom_sel},
                {15'd0, m_word[3] && rng(data_addr, 16'hF000, 16'hFFFF)});
            chk("R9 ext_addr", ext_addr, m_ext);
            chk("R10 clk_out", {15'd0, clk_out}, {15'd0, m_word[2]});
        end
    end

    task automatic step(input int n = 1);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            #1;
        end
    endtask

    logic [15:0] alist [9] = '{16'h0000, 16'h007F, 16'h0080, 16'h1234, 16'h3FFF,
                               16'h4000, 16'hEFFF, 16'hF000, 16'hFFFF};

    task automatic sweep(input bit fetch);
        for (int i = 0; i < 9; i++) begin
            prog_addr  = alist[i];
            data_addr  = alist[(i + 4) % 9];
            prog_fetch = fetch && (i % 2 == 0);
            step();
        end
        prog_fetch = 1'b0;
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            fails++;
            $display("FAIL watchdog: actual hung expected finish");
            summary();
            $finish;
        end
    end

    initial begin
        // R1: reset with pin high, vector at FF80h (R4)
        step(2);
        rst = 1'b0;
        step();
        // R11: pin moves outside reset
        mode_pin = 1'b0;
        step(2);
        for (int v = 0; v < 128; v += 63) begin
            vec_num = v[6:0];
            step();
        end
        // R5..R8 with reset word: ROM off in program, no overlay, no data ROM
        sweep(1'b1);
        // R2: pointer 2, ROM on, overlay, visibility, data ROM, clock parked
        wr_en = 1'b1; wr_data = 16'h013F;
        step();
        wr_en = 1'b0;
        sweep(1'b1);
        // R9: external access wins over a fetch, then hold
        prog_fetch = 1'b1; prog_addr = 16'h2222;
        ext_valid = 1'b1; ext_bus_addr = 16'hBEEF;
        step();
        ext_valid = 1'b0; prog_fetch = 1'b0; prog_addr = 16'h5555;
        step(2);
        // R3: soft reset with competing write
        soft_rst = 1'b1; wr_en = 1'b1; wr_data = 16'hFFC0;
        step();
        soft_rst = 1'b0; wr_en = 1'b0;
        sweep(1'b1);
        // R10: clock running, then visibility off and holding (R9)
        wr_en = 1'b1; wr_data = 16'h7F84;
        step();
        wr_data = 16'h7F80;
        step();
        wr_en = 1'b0;
        sweep(1'b0);
        // R1: hardware reset with pin low, ROM enabled
        rst = 1'b1;
        step(2);
        rst = 1'b0;
        mode_pin = 1'b1;
        sweep(1'b1);
        step(2);
        done = 1;
        summary();
        $finish;
    end
endmodule